// File: doc/BRIEF.md
# Shifter and Rotated-Immediate Operand Unit

This purely combinational unit builds the second operand and the shifter carry for an arithmetic/logic unit. In immediate mode it expands a 12-bit field into a 32-bit constant: the low eight bits are the constant, and the high four bits give a rotate-right distance that is doubled, so a small table-free encoding reaches values such as 4096 or 0x00FF0000.

In register mode it shifts a 32-bit register value by one of four shift kinds. The shift distance is either a 5-bit immediate or the low byte of a second register. It also forms the shifter carry-out from the last bit moved out, or from the incoming carry flag when nothing moves. A rotate through the carry flag by one place is selected by a rotate with a zero immediate distance. Decode, the ALU itself and the storage of flags sit outside.

Top module: `opshift_operand_unit`

## Requirements
- R1: With use_imm=1, operand equals imm_field[7:0], zero-extended to 32 bits and rotated right by 2*imm_field[11:8] places (for example field 0xD40 gives 0x00001000, field 0x8FF gives 0x00FF0000).
- R2: With use_imm=1, carry_out equals carry_in when imm_field[11:8] is zero, and equals operand[31] otherwise.
- R3: With use_imm=0, shift_kind selects 0 logical left, 1 logical right, 2 arithmetic right (sign-preserving), 3 rotate right. For distances 1 to 31 the operand is reg_val shifted by that distance, and carry_out is the last bit shifted out (for a rotate, operand[31]).
- R4: amt_from_reg=1 takes the distance from amt_reg (8 bits, 0 to 255). amt_from_reg=0 takes it from amt_imm (5 bits).
- R5: A register-sourced distance of zero passes reg_val to operand and carry_in to carry_out, for every shift kind.
- R6: A register distance of exactly 32 gives operand zero for both logical shifts, with carry_out reg_val[0] for a left shift and reg_val[31] for a right shift. Distances above 32 give operand zero and carry_out 0.
- R7: An arithmetic right shift by a register distance of 32 or more fills every operand bit with reg_val[31], and carry_out is reg_val[31].
- R8: A rotate by a register distance of 32 or more rotates by the distance modulo 32. A nonzero multiple of 32 leaves reg_val unchanged, with carry_out reg_val[31].
- R9: A rotate with amt_from_reg=0 and amt_imm=0 is a one-place rotate through carry. The operand is {carry_in, reg_val[31:1]} and carry_out is reg_val[0].
- R10: For the other three shift kinds, amt_from_reg=0 with amt_imm=0 passes reg_val and carry_in through unchanged.
- R11: With use_imm=1 the outputs depend on imm_field and carry_in only. reg_val, shift_kind, amt_from_reg, amt_imm and amt_reg have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the rotated-immediate operand, 0 selects the shifted register |
| imm_field | input | 12 | [11:8] rotate field (doubled), [7:0] constant |
| reg_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg | input | 1 | 1 takes the distance from amt_reg, 0 from amt_imm |
| amt_imm | input | 5 | Immediate shift distance |
| amt_reg | input | 8 | Low byte of the second register, used as the distance |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second operand for the ALU |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The hardest cases to reach are the carry results at the edges of the distance range. These are a distance of exactly 32 against 33, arithmetic fill beyond the width, rotates by nonzero multiples of 32, and a zero distance that means pass-through in one encoding and rotate-through-carry in the other. Ordinary operands rarely land there. The stimulus therefore sweeps every register distance from 0 to 66, plus 128 and 255, for every shift kind over several bit patterns, and every immediate distance 0 to 31. Each result is compared with a bit-at-a-time reference model. All 4096 immediate fields are also swept while the register-side inputs vary, so any leak from the register path into immediate mode shows up.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opshift_amt_sel.sv
module opshift_amt_sel
  import opshift_pkg::*;
#(
  parameter int SAMT_W = 5,
  parameter int RAMT_W = 8
) (
  input  logic              from_reg,
  input  logic [SAMT_W-1:0] amt_imm,
  input  logic [RAMT_W-1:0] amt_reg,
  input  shift_kind_e       kind,
  output logic [RAMT_W-1:0] amt,
  output logic              rrx_sel
);
  always_comb begin
    if (from_reg) amt = amt_reg;
    else          amt = RAMT_W'(amt_imm);
    rrx_sel = !from_reg && (kind == SH_ROR) && (amt_imm == '0);
  end

  // R4: an immediate-sourced distance never reaches beyond the 5-bit range
  always_comb begin
    if (!$isunknown({from_reg, amt_imm}) && !from_reg)
      assert_imm_amt_range_R4: assert (amt < RAMT_W'(2**SAMT_W));
  end

  // R9: rotate-through-carry is only chosen for an immediate zero distance
  always_comb begin
    if (!$isunknown({from_reg, amt_imm, kind}) && rrx_sel)
      assert_rrx_only_imm_R9: assert (!from_reg && amt == '0);
  end
endmodule

// File: rtl/opshift_barrel.sv
module opshift_barrel
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8
) (
  input  logic [DATA_W-1:0] value,
  input  shift_kind_e       kind,
  input  logic [RAMT_W-1:0] amt,
  input  logic              rrx_sel,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int ROTS_W = $clog2(DATA_W);

  logic [DATA_W:0]   lsl_w;
  logic [DATA_W:0]   lsr_w;
  logic [DATA_W:0]   asr_w;
  logic [DATA_W-1:0] ror_r;
  logic [ROTS_W-1:0] rot_amt;

  always_comb begin
    rot_amt = amt[ROTS_W-1:0];
    // left: result in [DATA_W-1:0], last bit out lands in [DATA_W]
    lsl_w = (DATA_W+1)'({{DATA_W{1'b0}}, value} << amt);
    // right: result in [DATA_W:1], last bit out lands in [0]
    lsr_w = {value, 1'b0} >> amt;
    asr_w = $unsigned($signed({value, 1'b0}) >>> amt);
    ror_r = DATA_W'({value, value} >> rot_amt);
  end

  always_comb begin
    res  = value;
    cout = cin;
    if (rrx_sel) begin
      res  = {cin, value[DATA_W-1:1]};
      cout = value[0];
    end else if (amt != '0) begin
      unique case (kind)
        SH_LSL: begin res = lsl_w[DATA_W-1:0]; cout = lsl_w[DATA_W]; end
        SH_LSR: begin res = lsr_w[DATA_W:1];   cout = lsr_w[0];      end
        SH_ASR: begin res = asr_w[DATA_W:1];   cout = asr_w[0];      end
        default: begin res = ror_r;            cout = ror_r[DATA_W-1]; end
      endcase
    end
  end

  // R5: zero distance leaves value and carry alone
  always_comb begin
    if (!$isunknown({value, kind, amt, rrx_sel, cin}) && !rrx_sel && amt == '0)
      assert_zero_amt_pass_R5: assert (res == value && cout == cin);
  end

  // R7: wide arithmetic shift is a pure sign fill
  always_comb begin
    if (!$isunknown({value, kind, amt, rrx_sel}) && !rrx_sel &&
        kind == SH_ASR && amt >= RAMT_W'(DATA_W))
      assert_asr_sign_fill_R7: assert (($countones(res) == 0 || $countones(res) == DATA_W)
                                       && res[0] == value[DATA_W-1] && cout == value[DATA_W-1]);
  end

  // R6: logical shifts by more than the width leave nothing behind
  always_comb begin
    if (!$isunknown({value, kind, amt, rrx_sel}) && !rrx_sel &&
        (kind == SH_LSL || kind == SH_LSR) && amt > RAMT_W'(DATA_W))
      assert_logic_wide_zero_R6: assert (res == '0 && !cout);
  end

  // R8: a rotate keeps the population count of the value
  always_comb begin
    if (!$isunknown({value, kind, amt, rrx_sel}) && !rrx_sel && kind == SH_ROR)
      assert_ror_popcount_R8: assert ($countones(res) == $countones(value));
  end

  // R9: rotate through carry moves one bit in and one bit out
  always_comb begin
    if (!$isunknown({value, rrx_sel, cin}) && rrx_sel)
      assert_rrx_bits_R9: assert (res[DATA_W-1] == cin && cout == value[0]
                                  && res[DATA_W-2:0] == value[DATA_W-1:1]);
  end
endmodule

// File: rtl/opshift_imm_rot.sv
module opshift_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [ROT_W-1:0] rot,
  input  logic [IMM_W-1:0] konst,
  input  logic             cin,
  output logic [DATA_W-1:0] res,
  output logic             cout
);
  logic [DATA_W-1:0] ext;
  logic [ROT_W:0]    rot_n;

  always_comb begin
    ext   = DATA_W'(konst);
    rot_n = {rot, 1'b0};
    res   = DATA_W'({ext, ext} >> rot_n);
    cout  = (rot == '0) ? cin : res[DATA_W-1];
  end

  // R1: rotation keeps every set bit of the constant
  always_comb begin
    if (!$isunknown({rot, konst}))
      assert_imm_popcount_R1: assert ($countones(res) == $countones(konst));
  end

  // R2: a zero rotate field leaves the constant in place with the old carry
  always_comb begin
    if (!$isunknown({rot, konst, cin}) && rot == '0)
      assert_imm_norot_R2: assert (res[IMM_W-1:0] == konst && cout == cin);
  end
endmodule

// File: rtl/opshift_operand_unit.sv
module opshift_operand_unit
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int SAMT_W = 5,
  parameter int RAMT_W = 8
) (
  input  logic                     use_imm,
  input  logic [ROT_W+IMM_W-1:0]   imm_field,
  input  logic [DATA_W-1:0]        reg_val,
  input  logic [1:0]               shift_kind,
  input  logic                     amt_from_reg,
  input  logic [SAMT_W-1:0]        amt_imm,
  input  logic [RAMT_W-1:0]        amt_reg,
  input  logic                     carry_in,
  output logic [DATA_W-1:0]        operand,
  output logic                     carry_out
);
  shift_kind_e       kind;
  logic [RAMT_W-1:0] amt;
  logic              rrx_sel;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic [DATA_W-1:0] im_res;
  logic              im_c;

  assign kind = shift_kind_e'(shift_kind);

  opshift_amt_sel #(.SAMT_W(SAMT_W), .RAMT_W(RAMT_W)) u_amt (
    .from_reg (amt_from_reg),
    .amt_imm  (amt_imm),
    .amt_reg  (amt_reg),
    .kind     (kind),
    .amt      (amt),
    .rrx_sel  (rrx_sel)
  );

  opshift_barrel #(.DATA_W(DATA_W), .RAMT_W(RAMT_W)) u_barrel (
    .value   (reg_val),
    .kind    (kind),
    .amt     (amt),
    .rrx_sel (rrx_sel),
    .cin     (carry_in),
    .res     (sh_res),
    .cout    (sh_c)
  );

  opshift_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .rot   (imm_field[ROT_W+IMM_W-1:IMM_W]),
    .konst (imm_field[IMM_W-1:0]),
    .cin   (carry_in),
    .res   (im_res),
    .cout  (im_c)
  );

  always_comb begin
    if (use_imm) begin
      operand   = im_res;
      carry_out = im_c;
    end else begin
      operand   = sh_res;
      carry_out = sh_c;
    end
  end

  // R11: in immediate mode the operand carries only the constant's bits
  always_comb begin
    if (!$isunknown({use_imm, imm_field}) && use_imm)
      assert_imm_mode_bits_R11: assert ($countones(operand) == $countones(imm_field[IMM_W-1:0]));
  end

  // R2: nonzero rotate gives the top operand bit as carry
  always_comb begin
    if (!$isunknown({use_imm, imm_field}) && use_imm && imm_field[ROT_W+IMM_W-1:IMM_W] != '0)
      assert_imm_carry_msb_R2: assert (carry_out == operand[DATA_W-1]);
  end
endmodule

// File: tb/tb_opshift_operand_unit.sv
module tb_opshift_operand_unit;
  logic        clk;
  logic        rst_n;
  logic        use_imm;
  logic [11:0] imm_field;
  logic [31:0] reg_val;
  logic [1:0]  shift_kind;
  logic        amt_from_reg;
  logic [4:0]  amt_imm;
  logic [7:0]  amt_reg;
  logic        carry_in;
  logic [31:0] operand;
  logic        carry_out;

  int checks;
  int errors;
  bit done;

  opshift_operand_unit dut (
    .use_imm      (use_imm),
    .imm_field    (imm_field),
    .reg_val      (reg_val),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .amt_imm      (amt_imm),
    .amt_reg      (amt_reg),
    .carry_in     (carry_in),
    .operand      (operand),
    .carry_out    (carry_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        ui;
    logic [11:0] imm;
    logic [31:0] val;
    logic [1:0]  kind;
    logic        fr;
    logic [4:0]  ai;
    logic [7:0]  ar;
    logic        cin;
    logic [31:0] eop;
    logic        ec;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{4'd1,  1'b1, 12'hD40, 32'h0,        2'd0, 1'b0, 5'd0, 8'd0,   1'b1, 32'h00001000, 1'b0}, // R1
    '{4'd1,  1'b1, 12'h8FF, 32'h0,        2'd0, 1'b0, 5'd0, 8'd0,   1'b0, 32'h00FF0000, 1'b0}, // R1
    '{4'd2,  1'b1, 12'h0AB, 32'hFFFFFFFF, 2'd0, 1'b1, 5'd4, 8'd4,   1'b1, 32'h000000AB, 1'b1}, // R2 R11
    '{4'd2,  1'b1, 12'h0AB, 32'h0,        2'd0, 1'b0, 5'd0, 8'd0,   1'b0, 32'h000000AB, 1'b0}, // R2
    '{4'd1,  1'b1, 12'h1FF, 32'h0,        2'd0, 1'b0, 5'd0, 8'd0,   1'b0, 32'hC000003F, 1'b1}, // R1
    '{4'd1,  1'b1, 12'hF01, 32'h0,        2'd0, 1'b0, 5'd0, 8'd0,   1'b1, 32'h00000004, 1'b0}, // R1
    '{4'd2,  1'b1, 12'h4F0, 32'h0,        2'd0, 1'b0, 5'd0, 8'd0,   1'b0, 32'hF0000000, 1'b1}, // R2
    '{4'd3,  1'b0, 12'h0,   32'h80000001, 2'd0, 1'b0, 5'd1, 8'd0,   1'b0, 32'h00000002, 1'b1}, // R3
    '{4'd3,  1'b0, 12'h0,   32'h80000001, 2'd1, 1'b0, 5'd1, 8'd0,   1'b0, 32'h40000000, 1'b1}, // R3
    '{4'd3,  1'b0, 12'h0,   32'h80000010, 2'd2, 1'b0, 5'd4, 8'd0,   1'b1, 32'hF8000001, 1'b0}, // R3
    '{4'd3,  1'b0, 12'h0,   32'h12345678, 2'd3, 1'b0, 5'd4, 8'd0,   1'b0, 32'h81234567, 1'b1}, // R3
    '{4'd9,  1'b0, 12'h0,   32'h00000003, 2'd3, 1'b0, 5'd0, 8'd0,   1'b1, 32'h80000001, 1'b1}, // R9
    '{4'd6,  1'b0, 12'h0,   32'h80000001, 2'd0, 1'b1, 5'd0, 8'd32,  1'b0, 32'h00000000, 1'b1}, // R6
    '{4'd8,  1'b0, 12'h0,   32'h12345678, 2'd3, 1'b1, 5'd0, 8'd36,  1'b0, 32'h81234567, 1'b1}, // R8
    '{4'd7,  1'b0, 12'h0,   32'h80000000, 2'd2, 1'b1, 5'd0, 8'd200, 1'b0, 32'hFFFFFFFF, 1'b1}, // R7
    '{4'd5,  1'b0, 12'h0,   32'h00000005, 2'd1, 1'b1, 5'd7, 8'd0,   1'b1, 32'h00000005, 1'b1}, // R5
    '{4'd10, 1'b0, 12'h0,   32'h80000000, 2'd2, 1'b0, 5'd0, 8'd9,   1'b0, 32'h80000000, 1'b0}, // R10
    '{4'd4,  1'b0, 12'h0,   32'h0000FF00, 2'd1, 1'b0, 5'd8, 8'd2,   1'b1, 32'h000000FF, 1'b0}, // R4
    '{4'd4,  1'b0, 12'h0,   32'h0000FF00, 2'd1, 1'b1, 5'd8, 8'd4,   1'b1, 32'h00000FF0, 1'b0}, // R4
    '{4'd6,  1'b0, 12'h0,   32'hFFFFFFFF, 2'd1, 1'b1, 5'd0, 8'd33,  1'b1, 32'h00000000, 1'b0}  // R6
  };

  // bit-at-a-time reference for the register path, returns {carry, result}
  function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
                                            input int n, input logic c, input bit rrx);
    logic [31:0] r;
    logic        cc;
    r  = v;
    cc = c;
    if (rrx) return {v[0], c, v[31:1]};
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin cc = r[31]; r = {r[30:0], 1'b0};  end
        2'd1: begin cc = r[0];  r = {1'b0, r[31:1]};  end
        2'd2: begin cc = r[0];  r = {r[31], r[31:1]}; end
        default: begin cc = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {cc, r};
  endfunction

  function automatic logic [32:0] ref_imm(input logic [11:0] f, input logic c);
    logic [31:0] r;
    r = {24'h0, f[7:0]};
    for (int i = 0; i < 2 * int'(f[11:8]); i++) r = {r[0], r[31:1]};
    return {(f[11:8] == 4'd0) ? c : r[31], r};
  endfunction

  task automatic check(input string tag, input logic [31:0] eop, input logic ec);
    checks++;
    if (operand !== eop || carry_out !== ec) begin
      errors++;
      $display("FAIL %s operand=%h carry=%b expected operand=%h carry=%b",
               tag, operand, carry_out, eop, ec);
    end
  endtask

  task automatic drive(input logic ui, input logic [11:0] imm, input logic [31:0] v,
                       input logic [1:0] k, input logic fr, input logic [4:0] ai,
                       input logic [7:0] ar, input logic c);
    @(posedge clk);
    use_imm = ui; imm_field = imm; reg_val = v; shift_kind = k;
    amt_from_reg = fr; amt_imm = ai; amt_reg = ar; carry_in = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [4];
    logic [32:0] e;
    string       tag;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    use_imm = 0; imm_field = '0; reg_val = '0; shift_kind = '0;
    amt_from_reg = 0; amt_imm = '0; amt_reg = '0; carry_in = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset-state idle inputs", 32'h0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].ui, VEC[i].imm, VEC[i].val, VEC[i].kind, VEC[i].fr,
            VEC[i].ai, VEC[i].ar, VEC[i].cin);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].eop, VEC[i].ec);
    end

    vals[0] = 32'h80000001; vals[1] = 32'h12345678;
    vals[2] = 32'hFFFFFFFF; vals[3] = 32'h5A5A0F0F;
    for (int vi = 0; vi < 4; vi++) begin
      for (int k = 0; k < 4; k++) begin
        for (int n = 0; n < 69; n++) begin
          int amt;
          amt = (n == 67) ? 128 : (n == 68) ? 255 : n;
          e = ref_shift(vals[vi], 2'(k), amt, vi[0], 1'b0);
          if (amt == 0)       tag = "R5";
          else if (amt < 32)  tag = "R3";
          else if (k < 2)     tag = "R6";
          else if (k == 2)    tag = "R7";
          else                tag = "R8";
          drive(1'b0, 12'hFFF, vals[vi], 2'(k), 1'b1, 5'(n), 8'(amt), vi[0]);
          check($sformatf("%s reg k=%0d amt=%0d", tag, k, amt), e[31:0], e[32]);
        end
        for (int n = 0; n < 32; n++) begin
          bit rrx;
          rrx = (k == 3) && (n == 0);
          e = ref_shift(vals[vi], 2'(k), n, ~vi[0], rrx);
          if (rrx)         tag = "R9";
          else if (n == 0) tag = "R10";
          else             tag = "R3";
          drive(1'b0, 12'h000, vals[vi], 2'(k), 1'b0, 5'(n), 8'(255 - n), ~vi[0]);
          check($sformatf("%s imm-amt k=%0d amt=%0d", tag, k, n), e[31:0], e[32]);
        end
      end
    end

    for (int f = 0; f < 4096; f++) begin
      logic c;
      c = f[0] ^ f[5];
      e = ref_imm(12'(f), c);
      drive(1'b1, 12'(f), 32'(f * 32'h9E3779B9), 2'(f), f[1], 5'(f), 8'(f), c);
      check($sformatf("R11 R1 R2 imm field=%h", f), e[31:0], e[32]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule